// File: doc/BRIEF.md
# CAN Frame Error Detector

This block watches the bit stream of one CAN node at the sample point and reports protocol violations as they happen. A frame sequencer elsewhere in the node tells it where the current bit sits in the frame. It marks the arbitration field, the acknowledge slot, the CRC delimiter, the acknowledge delimiter, end of frame, intermission and the stuffed region. It also marks the start-of-frame bit and says whether the node is currently the transmitter. The block compares the bit the node sent with the level sampled on the bus on every sample strobe. From that comparison and the field position it raises four separate error pulses. It also raises a combined request to start an error frame.

The error-frame generator uses the combined request to abort the frame and schedule a retransmission. The four individual pulses feed the node's error counters and its diagnostics. Frame sequencing, CRC, destuffing of payload data and the error frame itself belong to other blocks.

Top module: `can_frame_err_det`

## Requirements
- R1: Bus levels are encoded dominant = 0 and recessive = 1. All five outputs are registered. They are 0 during and after synchronous reset. An error seen on a strobe cycle appears on the outputs in the following clock cycle only, so each error produces a pulse exactly one cycle wide.
- R2: When the node is transmitter and a strobe falls in the acknowledge slot, a recessive (1) sample raises `ack_err_o`. A dominant sample in the slot is a valid acknowledge and raises nothing.
- R3: When the node is not the transmitter, the acknowledge slot is never checked and `ack_err_o` stays 0.
- R4: A dominant (0) sample in the CRC delimiter, the acknowledge delimiter, end of frame or intermission raises `form_err_o`. This holds whether or not the node is transmitter.
- R5: When the node is transmitter, a strobe whose sampled bit differs from the sent bit raises `bit_err_o`. This includes a dominant bit sent and a recessive bit read inside the arbitration field.
- R6: A recessive bit sent and a dominant bit read during the arbitration field or the acknowledge slot does not raise `bit_err_o`.
- R7: When the node is not the transmitter, `bit_err_o` stays 0 whatever the sent and sampled bits are.
- R8: Inside the stuffed region, a run of six sampled bits of equal value raises `stuff_err_o` on the sixth bit. The run restarts at one on a polarity change and on the start-of-frame bit. This check applies in both roles.
- R9: A run longer than six raises `stuff_err_o` only once, on the sixth bit. A strobe outside the stuffed region clears the run, so bits on either side of such a strobe do not add up.
- R10: Errors detected on the same bit are all reported in the same cycle. `errfrm_req_o` is 1 exactly when at least one of the four error outputs is 1.
- R11: Cycles without a sample strobe raise no output and leave the run count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb_i | input | 1 | One-cycle strobe at the bit sample point |
| tx_bit_i | input | 1 | Bit the node is driving (0 dominant) |
| rx_bit_i | input | 1 | Bus level sampled at the strobe (0 dominant) |
| is_tx_i | input | 1 | Node is currently transmitter of the frame |
| in_sof_i | input | 1 | Current bit is start of frame |
| in_arb_i | input | 1 | Current bit is in the arbitration field |
| in_ack_slot_i | input | 1 | Current bit is the acknowledge slot |
| in_crc_dlm_i | input | 1 | Current bit is the CRC delimiter |
| in_ack_dlm_i | input | 1 | Current bit is the acknowledge delimiter |
| in_eof_i | input | 1 | Current bit is in end of frame |
| in_ifs_i | input | 1 | Current bit is in intermission |
| in_stuffed_i | input | 1 | Current bit lies in the stuffed region |
| ack_err_o | output | 1 | Acknowledge error pulse |
| form_err_o | output | 1 | Form error pulse |
| bit_err_o | output | 1 | Bit error pulse |
| stuff_err_o | output | 1 | Stuff error pulse |
| errfrm_req_o | output | 1 | Request to start an error frame |

## Verification
The bench targets several corner cases, each paired with the failure it would expose:

- Arbitration exemption: a design that exempts the wrong direction would either flag lost arbitration as a bit error or miss a dominant bit that was overwritten.
- Run lengths of five, six and seven: an off-by-one counter would flag a legal run of five, or flag the seventh bit a second time.
- Stuffed-region boundaries: a counter that ignores start of frame or out-of-region strobes would stitch two separate runs into a false stuff error.
- Role checks: acknowledge and bit checks are driven while the node is a receiver, to catch a design that leaks them into that role.
- Strobe gating: mismatched bits are held on non-strobe cycles, to catch a design that checks them anyway.
- Shared bits: bits that carry more than one error at once are driven, to catch a design that drops one of them.

// File: rtl/cfe_pkg.sv
package cfe_pkg;
  // Field qualifier vector layout (order is internal only)
  localparam int NUM_FLD      = 8;
  localparam int FLD_SOF      = 0;
  localparam int FLD_ARB      = 1;
  localparam int FLD_ACK_SLOT = 2;
  localparam int FLD_CRC_DLM  = 3;
  localparam int FLD_ACK_DLM  = 4;
  localparam int FLD_EOF      = 5;
  localparam int FLD_IFS      = 6;
  localparam int FLD_STUFF    = 7;

  // Fields in which a dominant sample is a form violation
  localparam logic [NUM_FLD-1:0] FORM_MASK_DEF =
    (NUM_FLD'(1) << FLD_CRC_DLM) | (NUM_FLD'(1) << FLD_ACK_DLM) |
    (NUM_FLD'(1) << FLD_EOF)     | (NUM_FLD'(1) << FLD_IFS);

  localparam logic DOMINANT  = 1'b0;
  localparam logic RECESSIVE = 1'b1;

  typedef struct packed {
    logic ack;
    logic form;
    logic bit_e;
    logic stuff;
  } err_vec_t;
endpackage

// File: rtl/cfe_tx_mon.sv
module cfe_tx_mon
  import cfe_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic stb,
  input  logic is_tx,
  input  logic tx_bit,
  input  logic rx_bit,
  input  logic in_arb,
  input  logic in_ack_slot,
  output logic ack_hit,
  output logic bit_hit
);
  logic mismatch;
  logic lost_arb_or_acked;

  always_comb begin
    mismatch          = (tx_bit != rx_bit);
    lost_arb_or_acked = (tx_bit == RECESSIVE) && (rx_bit == DOMINANT) &&
                        (in_arb || in_ack_slot);
    ack_hit = stb && is_tx && in_ack_slot && (rx_bit == RECESSIVE);
    bit_hit = stb && is_tx && mismatch && !lost_arb_or_acked;
  end

  // R7: receiver role never produces a transmit-side hit
  p_rx_silent_r7: assert property (@(posedge clk) disable iff (rst)
    !is_tx |-> !(ack_hit || bit_hit));
endmodule

// File: rtl/cfe_form_chk.sv
module cfe_form_chk
  import cfe_pkg::*;
#(
  parameter int                NFLD      = NUM_FLD,
  parameter logic [NFLD-1:0]   FORM_MASK = FORM_MASK_DEF
)(
  input  logic            clk,
  input  logic            rst,
  input  logic            stb,
  input  logic            rx_bit,
  input  logic [NFLD-1:0] fld,
  output logic            form_hit
);
  logic [NFLD-1:0] fixed_fld;

  for (genvar g = 0; g < NFLD; g++) begin : g_fld
    assign fixed_fld[g] = fld[g] & FORM_MASK[g];
  end

  assign form_hit = stb && (rx_bit == DOMINANT) && (|fixed_fld);

  // R4: a recessive sample never forms a form violation
  p_form_needs_dom_r4: assert property (@(posedge clk) disable iff (rst)
    (rx_bit == RECESSIVE) |-> !form_hit);
endmodule

// File: rtl/cfe_stuff_chk.sv
module cfe_stuff_chk
  import cfe_pkg::*;
#(
  parameter int RUN_LIMIT = 6
)(
  input  logic clk,
  input  logic rst,
  input  logic stb,
  input  logic rx_bit,
  input  logic in_sof,
  input  logic in_stuff,
  output logic stuff_hit
);
  localparam int CNT_W = $clog2(RUN_LIMIT + 1);
  localparam logic [CNT_W-1:0] LIM     = CNT_W'(RUN_LIMIT);
  localparam logic [CNT_W-1:0] LIM_M1  = CNT_W'(RUN_LIMIT - 1);

  logic [CNT_W-1:0] run_cnt;
  logic             run_val;
  logic             same;

  assign same      = (run_cnt != '0) && (rx_bit == run_val) && !in_sof;
  assign stuff_hit = stb && in_stuff && same && (run_cnt == LIM_M1);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
      run_val <= RECESSIVE;
    end else if (stb) begin
      if (!in_stuff) begin
        run_cnt <= '0;
      end else begin
        run_val <= rx_bit;
        if (!same)               run_cnt <= CNT_W'(1);
        else if (run_cnt != LIM) run_cnt <= run_cnt + 1'b1;
      end
    end
  end

  // R9: the run count never goes past the limit
  p_run_bound_r9: assert property (@(posedge clk) disable iff (rst)
    run_cnt <= LIM);
  // R8: start of frame restarts the run at one
  p_sof_restart_r8: assert property (@(posedge clk) disable iff (rst)
    (stb && in_stuff && in_sof) |=> (run_cnt == CNT_W'(1)));
  // R11: no strobe, no change of run state
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !stb |=> $stable(run_cnt));
endmodule

// File: rtl/can_frame_err_det.sv
module can_frame_err_det
  import cfe_pkg::*;
#(
  parameter int RUN_LIMIT = 6
)(
  input  logic clk,
  input  logic rst,
  input  logic smp_stb_i,
  input  logic tx_bit_i,
  input  logic rx_bit_i,
  input  logic is_tx_i,
  input  logic in_sof_i,
  input  logic in_arb_i,
  input  logic in_ack_slot_i,
  input  logic in_crc_dlm_i,
  input  logic in_ack_dlm_i,
  input  logic in_eof_i,
  input  logic in_ifs_i,
  input  logic in_stuffed_i,
  output logic ack_err_o,
  output logic form_err_o,
  output logic bit_err_o,
  output logic stuff_err_o,
  output logic errfrm_req_o
);
  logic [NUM_FLD-1:0] fld;
  err_vec_t           hit;
  err_vec_t           err_q;
  logic               req_q;

  always_comb begin
    fld               = '0;
    fld[FLD_SOF]      = in_sof_i;
    fld[FLD_ARB]      = in_arb_i;
    fld[FLD_ACK_SLOT] = in_ack_slot_i;
    fld[FLD_CRC_DLM]  = in_crc_dlm_i;
    fld[FLD_ACK_DLM]  = in_ack_dlm_i;
    fld[FLD_EOF]      = in_eof_i;
    fld[FLD_IFS]      = in_ifs_i;
    fld[FLD_STUFF]    = in_stuffed_i;
  end

  cfe_tx_mon u_tx_mon (
    .clk(clk), .rst(rst), .stb(smp_stb_i), .is_tx(is_tx_i),
    .tx_bit(tx_bit_i), .rx_bit(rx_bit_i),
    .in_arb(fld[FLD_ARB]), .in_ack_slot(fld[FLD_ACK_SLOT]),
    .ack_hit(hit.ack), .bit_hit(hit.bit_e)
  );

  cfe_form_chk #(.NFLD(NUM_FLD), .FORM_MASK(FORM_MASK_DEF)) u_form (
    .clk(clk), .rst(rst), .stb(smp_stb_i), .rx_bit(rx_bit_i),
    .fld(fld), .form_hit(hit.form)
  );

  cfe_stuff_chk #(.RUN_LIMIT(RUN_LIMIT)) u_stuff (
    .clk(clk), .rst(rst), .stb(smp_stb_i), .rx_bit(rx_bit_i),
    .in_sof(fld[FLD_SOF]), .in_stuff(fld[FLD_STUFF]),
    .stuff_hit(hit.stuff)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q <= '0;
      req_q <= 1'b0;
    end else begin
      err_q <= hit;
      req_q <= |hit;
    end
  end

  assign ack_err_o    = err_q.ack;
  assign form_err_o   = err_q.form;
  assign bit_err_o    = err_q.bit_e;
  assign stuff_err_o  = err_q.stuff;
  assign errfrm_req_o = req_q;

  // R1: every error pulse follows a strobe
  p_after_stb_r1: assert property (@(posedge clk) disable iff (rst)
    errfrm_req_o |-> $past(smp_stb_i));
  // R3: receiver role gives no acknowledge error
  p_rx_no_ack_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(is_tx_i) |-> !ack_err_o);
  // R6: lost arbitration or a received acknowledge is not a bit error
  p_arb_exempt_r6: assert property (@(posedge clk) disable iff (rst)
    $past(smp_stb_i && (in_arb_i || in_ack_slot_i) && tx_bit_i && !rx_bit_i)
    |-> !bit_err_o);
  // R4: form error only after a dominant sample
  p_form_dom_r4: assert property (@(posedge clk) disable iff (rst)
    form_err_o |-> !$past(rx_bit_i));
  // R10: request present iff some error is present
  p_req_any_r10: assert property (@(posedge clk) disable iff (rst)
    errfrm_req_o == (ack_err_o || form_err_o || bit_err_o || stuff_err_o));
  // R11: no strobe, no request
  p_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !$past(smp_stb_i) |-> !errfrm_req_o);
endmodule

// File: tb/tb_can_frame_err_det.sv
module tb_can_frame_err_det;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stb = 0, txb = 1, rxb = 1, istx = 0, sof = 0, arb = 0, acks = 0;
  logic crcd = 0, ackd = 0, eof = 0, ifs = 0, stf = 0;
  logic ack_o, form_o, bit_o, stuff_o, req_o;

  int checks = 0, failures = 0;
  int run_m = 0;
  logic last_m = 1'b1;
  bit done = 0;

  always #10 clk = ~clk;

  can_frame_err_det dut (
    .clk(clk), .rst(rst), .smp_stb_i(stb), .tx_bit_i(txb), .rx_bit_i(rxb),
    .is_tx_i(istx), .in_sof_i(sof), .in_arb_i(arb), .in_ack_slot_i(acks),
    .in_crc_dlm_i(crcd), .in_ack_dlm_i(ackd), .in_eof_i(eof), .in_ifs_i(ifs),
    .in_stuffed_i(stf), .ack_err_o(ack_o), .form_err_o(form_o),
    .bit_err_o(bit_o), .stuff_err_o(stuff_o), .errfrm_req_o(req_o)
  );

  function automatic bit exp_ack();
    return stb && istx && acks && rxb;
  endfunction
  function automatic bit exp_form();
    return stb && !rxb && (crcd || ackd || eof || ifs);
  endfunction
  function automatic bit exp_bit();
    if (!(stb && istx) || txb == rxb) return 0;
    if (txb && !rxb && (arb || acks)) return 0;
    return 1;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  // Drive current inputs for one cycle (already set at negedge), compare next negedge
  task automatic step();
    bit ea, ef, eb, es;
    ea = exp_ack(); ef = exp_form(); eb = exp_bit(); es = 0;
    if (stb) begin
      if (!stf) run_m = 0;
      else begin
        if (run_m != 0 && rxb == last_m && !sof) begin
          es = (run_m == 5);
          if (run_m < 6) run_m++;
        end else run_m = 1;
        last_m = rxb;
      end
    end
    @(negedge clk);
    chk("R2", ack_o, ea);
    chk("R4", form_o, ef);
    chk("R5", bit_o, eb);
    chk("R8", stuff_o, es);
    chk("R10", req_o, ea | ef | eb | es);
  endtask

  task automatic clr();
    stb = 0; txb = 1; rxb = 1; istx = 0; sof = 0; arb = 0; acks = 0;
    crcd = 0; ackd = 0; eof = 0; ifs = 0; stf = 0;
  endtask

  task automatic bitv(logic t, logic r);
    stb = 1; txb = t; rxb = r; step(); stb = 0; step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    clr();
    repeat (3) @(negedge clk);
    // R1: outputs are zero while in reset
    chk("R1", req_o | ack_o | form_o | bit_o | stuff_o, 1'b0);
    rst = 0;
    @(negedge clk);
    chk("R1", req_o, 1'b0);

    // R2: ack slot, transmitter, recessive then dominant
    istx = 1; acks = 1; bitv(1, 1); bitv(1, 0);
    // R1: pulse lasts one cycle - step after bitv already checked zero
    // R3: receiver, recessive ack slot
    istx = 0; bitv(1, 1); clr();
    // R4: each form field with dominant, then recessive
    crcd = 1; bitv(1, 0); bitv(1, 1); crcd = 0;
    ackd = 1; bitv(1, 0); ackd = 0;
    eof = 1;  bitv(1, 0); eof = 0;
    ifs = 1;  istx = 1; bitv(0, 0); ifs = 0; istx = 0;
    // R5: data mismatch both ways; arbitration dominant sent, recessive read
    istx = 1; bitv(0, 1); bitv(1, 0); arb = 1; bitv(0, 1);
    // R6: arbitration recessive sent, dominant read
    bitv(1, 0); arb = 0; acks = 1; bitv(1, 0); acks = 0;
    // R7: receiver mismatch
    istx = 0; bitv(0, 1); bitv(1, 0);
    // R8: five equal then break, then six from SOF
    stf = 1; sof = 1; bitv(1, 0); sof = 0;
    for (int i = 0; i < 4; i++) bitv(1, 0);
    bitv(1, 1);
    for (int i = 0; i < 5; i++) bitv(1, 1);
    // R9: seventh equal bit flags nothing more
    bitv(1, 1); bitv(1, 1);
    // R9: out-of-region strobe splits runs
    for (int i = 0; i < 3; i++) bitv(0, 0);
    stf = 0; bitv(0, 0); stf = 1;
    for (int i = 0; i < 3; i++) bitv(0, 0);
    // R8: SOF restarts a run in progress
    sof = 1; bitv(0, 0); sof = 0;
    for (int i = 0; i < 5; i++) bitv(0, 0);
    stf = 0;
    // R10: ack delimiter dominant while sending recessive: form + bit
    istx = 1; ackd = 1; bitv(1, 0); ackd = 0;
    // R11: mismatches held without strobe
    stb = 0; txb = 0; rxb = 1; crcd = 1; acks = 1;
    for (int i = 0; i < 4; i++) step();
    clr();

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      int f;
      clr();
      stb  = ($urandom % 4) != 0;
      istx = $urandom % 2;
      txb  = $urandom % 2;
      rxb  = ($urandom % 3 == 0) ? ~txb : txb;
      f = $urandom % 9;
      case (f)
        0: arb = 1; 1: acks = 1; 2: crcd = 1; 3: ackd = 1;
        4: eof = 1; 5: ifs = 1; default: ;
      endcase
      stf = ($urandom % 3) != 0;
      if (stf && ($urandom % 40 == 0)) sof = 1;
      if (stf && ($urandom % 2 == 0)) rxb = last_m;
      step();
    end
    clr();
    step();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule